// File: doc/BRIEF.md
# Four-Bit Cascadable ALU Slice

This block is a purely combinational 4-bit arithmetic and logic slice. Two operands and a 4-bit function code go in. A mode input chooses how the function code is read. When the mode input is high, the slice produces one of the sixteen bitwise Boolean functions of two variables. When it is low, the slice produces one of sixteen arithmetic operations, each formed as the sum of two operand-derived terms plus a carry. Data is active-high, while the ripple carry pins are active-low.

Wider words can be built in two ways. Slices can be chained by connecting each carry-out to the next carry-in. Alternatively, each slice exports a group generate and a group propagate term, so an external lookahead unit can form the carries across many slices at once. An equality flag is decoded from the result bits. In the subtract function with no carry applied, this flag reports A equal to B, and the carry-out reports the relative magnitude of A and B.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode`=1, `result` for `sel` 0 to 15 is, in that order: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, 4'hF, A|~B, A|B, A.
- R2: With `logic_mode`=0, `result` is the low 4 bits of X+Y+c. Here c = ~`carry_in_n`, and the pair (X,Y) for `sel` 0 to 15 is: (A,0), (A|B,0), (A|~B,0), (15,0), (A,A&~B), (A|B,A&~B), (A,~B), (A&~B,15), (A,A&B), (A,B), (A|~B,A&B), (A&B,15), (A,A), (A|B,A), (A|~B,A), (A,15).
- R3: `carry_out_n` is low exactly when the 5-bit sum X+Y+c of R2 exceeds 15. This holds for either value of `logic_mode`.
- R4: With `sel`=6 and `logic_mode`=0, `result` is A-B-1 mod 16 when `carry_in_n`=1, and A-B mod 16 when `carry_in_n`=0.
- R5: `eq_flag` is 1 exactly when all four `result` bits are 1. With `sel`=6, `logic_mode`=0 and `carry_in_n`=1, this means A equals B.
- R6: With `sel`=6 and `logic_mode`=0, `carry_out_n` is low exactly when A>B (for `carry_in_n`=1) or when A>=B (for `carry_in_n`=0).
- R7: `grp_gen` equals the carry out of X+Y with no carry-in. `grp_gen`|`grp_prop` equals the carry out of X+Y+1, so that carry-out = `grp_gen` | (`grp_prop` & c).
- R8: Two slices chained by ripple give the same 8-bit result and final carry as two slices whose upper carry-in comes from the group terms of the lower slice.
- R9: With `logic_mode`=1, `result` does not depend on `carry_in_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| sel | input | 4 | Function code |
| logic_mode | input | 1 | 1: bitwise logic, 0: arithmetic |
| carry_in_n | input | 1 | Ripple carry-in, active-low |
| result | output | 4 | Function result |
| carry_out_n | output | 1 | Ripple carry-out, active-low |
| grp_prop | output | 1 | Group carry-propagate, active-high |
| grp_gen | output | 1 | Group carry-generate, active-high |
| eq_flag | output | 1 | All result bits set |

## Verification
The hardest behaviour to reach from the ports is the split between `grp_gen` and `grp_prop`. A single slice only shows their OR through its own carry-out, so a wrong propagate term can stay hidden unless the carry-in toggles for the same operands. The stimulus therefore sweeps every operand, function code and mode with both carry values. It also drives a two-slice chain whose upper carry-in comes from lookahead, and compares that chain with a rippled pair over spread operand values in the add and subtract functions.

// File: rtl/alu4_slice.sv
module alu4_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   sel,
  input  logic         logic_mode,
  input  logic         carry_in_n,
  output logic [W-1:0] result,
  output logic         carry_out_n,
  output logic         grp_prop,
  output logic         grp_gen,
  output logic         eq_flag
);

  logic [W-1:0] pt, gt, hs, gacc;
  logic [W:0]   cy;

  assign pt = a_in | ({W{sel[0]}} & b_in) | ({W{sel[1]}} & ~b_in);
  assign gt = ({W{sel[2]}} & a_in & ~b_in) | ({W{sel[3]}} & a_in & b_in);
  assign hs = pt ^ gt;
  assign cy[0] = ~carry_in_n;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign cy[i+1] = gt[i] | (pt[i] & cy[i]);
    if (i == 0) begin : g_first
      assign gacc[i] = gt[i];
    end else begin : g_rest
      assign gacc[i] = gt[i] | (pt[i] & gacc[i-1]);
    end
  end

  assign grp_gen     = gacc[W-1];
  assign grp_prop    = &pt;
  assign result      = logic_mode ? ~hs : (hs ^ cy[W-1:0]);
  assign carry_out_n = ~(grp_gen | (grp_prop & cy[0]));
  assign eq_flag     = &result;

  always_comb begin
    // R3
    cout_chain_chk: assert (carry_out_n == ~cy[W])
      else $error("group carry disagrees with bit chain");
    // R2
    if (!logic_mode)
      sum_width_chk: assert ({~carry_out_n, result} ==
                             ({1'b0, pt} + {1'b0, gt} + {{W{1'b0}}, cy[0]}))
        else $error("arithmetic result is not the operand sum");
    // R5
    if (!logic_mode && sel == 4'd6 && carry_in_n)
      equal_flag_chk: assert (eq_flag == (a_in == b_in))
        else $error("equality flag wrong in subtract");
    // R6
    if (!logic_mode && sel == 4'd6)
      magnitude_chk: assert (~carry_out_n == (carry_in_n ? (a_in > b_in) : (a_in >= b_in)))
        else $error("carry-out magnitude test wrong");
    // R1
    if (logic_mode && sel == 4'd11)
      and_func_chk: assert (result == (a_in & b_in))
        else $error("logic AND function wrong");
  end

endmodule

// File: tb/alu4_slice_bench.sv
module alu4_slice_bench;

  typedef struct {
    logic [3:0] f;
    logic       co_n;
    logic       eq;
    logic       g;
    logic       gp;
    logic [3:0] s;
    logic       m;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  logic [3:0] a, b, s, f;
  logic       m, cin_n, co_n, gp, gg, eq;

  alu4_slice u_alu4_slice (
    .a_in(a), .b_in(b), .sel(s), .logic_mode(m), .carry_in_n(cin_n),
    .result(f), .carry_out_n(co_n), .grp_prop(gp), .grp_gen(gg), .eq_flag(eq));

  logic [3:0] la, lb, ha, hb, cs, lf, hf, xf;
  logic       cc_n, lco_n, hco_n, xco_n, lp, lg, hp, hg, xp, xg, leq, heq, xeq, xcin_n;

  alu4_slice u_lo (.a_in(la), .b_in(lb), .sel(cs), .logic_mode(1'b0), .carry_in_n(cc_n),
    .result(lf), .carry_out_n(lco_n), .grp_prop(lp), .grp_gen(lg), .eq_flag(leq));
  alu4_slice u_hi (.a_in(ha), .b_in(hb), .sel(cs), .logic_mode(1'b0), .carry_in_n(lco_n),
    .result(hf), .carry_out_n(hco_n), .grp_prop(hp), .grp_gen(hg), .eq_flag(heq));
  assign xcin_n = ~(lg | (lp & ~cc_n));
  alu4_slice u_la (.a_in(ha), .b_in(hb), .sel(cs), .logic_mode(1'b0), .carry_in_n(xcin_n),
    .result(xf), .carry_out_n(xco_n), .grp_prop(xp), .grp_gen(xg), .eq_flag(xeq));

  function automatic logic [4:0] arith(input logic [3:0] x, input logic [3:0] y,
                                       input logic [3:0] sl, input logic c);
    logic [3:0] p, q;
    case (sl)
      4'd0:  begin p = x;      q = 4'd0;   end
      4'd1:  begin p = x | y;  q = 4'd0;   end
      4'd2:  begin p = x | ~y; q = 4'd0;   end
      4'd3:  begin p = 4'd15;  q = 4'd0;   end
      4'd4:  begin p = x;      q = x & ~y; end
      4'd5:  begin p = x | y;  q = x & ~y; end
      4'd6:  begin p = x;      q = ~y;     end
      4'd7:  begin p = x & ~y; q = 4'd15;  end
      4'd8:  begin p = x;      q = x & y;  end
      4'd9:  begin p = x;      q = y;      end
      4'd10: begin p = x | ~y; q = x & y;  end
      4'd11: begin p = x & y;  q = 4'd15;  end
      4'd12: begin p = x;      q = x;      end
      4'd13: begin p = x | y;  q = x;      end
      4'd14: begin p = x | ~y; q = x;      end
      default: begin p = x;    q = 4'd15;  end
    endcase
    return {1'b0, p} + {1'b0, q} + {4'd0, c};
  endfunction

  function automatic logic [3:0] boolf(input logic [3:0] x, input logic [3:0] y,
                                       input logic [3:0] sl);
    case (sl)
      4'd0:  return ~x;
      4'd1:  return ~(x | y);
      4'd2:  return ~x & y;
      4'd3:  return 4'd0;
      4'd4:  return ~(x & y);
      4'd5:  return ~y;
      4'd6:  return x ^ y;
      4'd7:  return x & ~y;
      4'd8:  return ~x | y;
      4'd9:  return ~(x ^ y);
      4'd10: return y;
      4'd11: return x & y;
      4'd12: return 4'hF;
      4'd13: return x | ~y;
      4'd14: return x | y;
      default: return x;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [3:0] x, input logic [3:0] y, input logic [3:0] sl,
                       input logic md, input logic ci_n);
    exp_t e;
    logic [4:0] r, r0, r1;
    @(posedge clk);
    a = x; b = y; s = sl; m = md; cin_n = ci_n;
    r  = arith(x, y, sl, ~ci_n);
    r0 = arith(x, y, sl, 1'b0);
    r1 = arith(x, y, sl, 1'b1);
    e.f    = md ? boolf(x, y, sl) : r[3:0];
    e.co_n = ~r[4];
    e.eq   = &e.f;
    e.g    = r0[4];
    e.gp   = r1[4];
    e.s    = sl;
    e.m    = md;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.m)
        check(f == e.f, "R1 R9 logic result", int'(f), int'(e.f));
      else if (e.s == 4'd6)
        check(f == e.f, "R4 subtract result", int'(f), int'(e.f));
      else
        check(f == e.f, "R2 arithmetic result", int'(f), int'(e.f));
      if (!e.m && e.s == 4'd6)
        check(co_n == e.co_n, "R6 magnitude carry", int'(co_n), int'(e.co_n));
      else
        check(co_n == e.co_n, "R3 carry-out", int'(co_n), int'(e.co_n));
      check(eq == e.eq, "R5 equality flag", int'(eq), int'(e.eq));
      check(gg == e.g, "R7 group generate", int'(gg), int'(e.g));
      check((gg | gp) == e.gp, "R7 group gen|prop", int'(gg | gp), int'(e.gp));
    end
  end

  task automatic cascade(input logic [7:0] x, input logic [7:0] y, input logic [3:0] sl,
                         input logic ci_n);
    logic [8:0] ref8;
    @(posedge clk);
    la = x[3:0]; lb = y[3:0]; ha = x[7:4]; hb = y[7:4]; cs = sl; cc_n = ci_n;
    ref8 = (sl == 4'd9) ? ({1'b0, x} + {1'b0, y} + {8'd0, ~ci_n})
                        : ({1'b0, x} + {1'b0, ~y} + {8'd0, ~ci_n});
    @(negedge clk);
    check({hf, lf} == ref8[7:0], "R8 ripple pair sum", int'({hf, lf}), int'(ref8[7:0]));
    check({xf, lf} == {hf, lf}, "R8 lookahead vs ripple result", int'({xf, lf}), int'({hf, lf}));
    check(xco_n == hco_n, "R8 lookahead vs ripple carry", int'(xco_n), int'(hco_n));
    check(~(hg | (hp & ~lco_n)) == ~ref8[8], "R8 group final carry",
          int'(~(hg | (hp & ~lco_n))), int'(~ref8[8]));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    a = '0; b = '0; s = '0; m = 1'b0; cin_n = 1'b1;
    la = '0; lb = '0; ha = '0; hb = '0; cs = 4'd9; cc_n = 1'b1;
    for (int md = 0; md < 2; md++)
      for (int ci = 0; ci < 2; ci++)
        for (int sl = 0; sl < 16; sl++)
          for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
              drive(4'(x), 4'(y), 4'(sl), 1'(md), 1'(ci));
    repeat (2) @(posedge clk);
    for (int x = 0; x < 256; x += 7)
      for (int y = 0; y < 256; y += 37)
        for (int ci = 0; ci < 2; ci++) begin
          cascade(8'(x), 8'(y), 4'd9, 1'(ci));
          cascade(8'(x), 8'(y), 4'd6, 1'(ci));
        end
    cascade(8'hFF, 8'h01, 4'd9, 1'b1);
    cascade(8'h0F, 8'h00, 4'd9, 1'b0);
    cascade(8'h5A, 8'h5A, 4'd6, 1'b1);
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

endmodule